// File: doc/BRIEF.md
# Serial Transmitter/Receiver with Data and Line Inversion

This block is a full-duplex asynchronous serial channel: a transmitter that turns one byte into a framed bit stream on `txd`, and a receiver that rebuilds bytes from `rxd`. Every bit lasts sixteen pulses of the external `tick16` strobe. The frame begins with a start bit, carries eight data bits, can include a parity bit, and ends with one or two stop bits. The data bits go out either least-significant first or most-significant first.

There are two separate inversion controls. `cfg_data_inv` complements the eight data bits where they enter and leave the block: on the way into the transmit shifter, and on the way out to the read port. Framing bits are never affected by it. `cfg_line_inv` sits at the pins. It swaps every level on `txd` (idle, start, data, parity, stop) and complements `rxd` before any receive decoding. Parity is formed over the data bits as they appear on the line, so it sees the effect of `cfg_data_inv` but not of `cfg_line_inv`.

The write side uses a valid/ready handshake. The read side holds a received byte with `rd_valid` and error flags until `rd_ack` takes it.

Top module: `uart_inv_top`

## Requirements
- R1: After reset, `tx_busy` and `rd_valid` are 0, `wr_ready` is 1, all error flags are 0, and `txd` rests at the idle level (1 XOR `cfg_line_inv`).
- R2: With `cfg_line_inv`=0, the transmitted frame is a start bit at 0, eight data bits, an optional parity bit and stop bits at 1. Each bit lasts 16 `tick16` pulses.
- R3: With `cfg_msb_first`=0, bit 0 of the data is sent first. With `cfg_msb_first`=1, bit 7 is sent first. The receiver reassembles the byte in the same order.
- R4: With `cfg_par_en`=1, one parity bit follows the last data bit. Its value is the XOR of the eight data bits as sent on the line, XORed with `cfg_par_odd` (0 = even, 1 = odd). With `cfg_par_en`=0, the stop bit follows the data directly.
- R5: `cfg_two_stop`=0 gives one stop bit and `cfg_two_stop`=1 gives two.
- R6: With `cfg_data_inv`=1, the data bits sent on the line are the complement of `wr_data`, and `rd_data` is the complement of the data bits received on the line.
- R7: With `cfg_line_inv`=1, every level on `txd` is inverted, including idle, start, parity and stop. `rxd` is inverted before receive decoding.
- R8: A write is accepted only while `wr_ready`=1, which is exactly while the transmitter is idle. `tx_busy` is 1 from the first cycle of the start bit until the end of the last stop bit.
- R9: The receiver samples each bit at its middle. It drops a start bit that is no longer active at mid-bit and produces no byte for it.
- R10: `err_frame` is set with the byte when any stop bit samples at the wrong level.
- R11: `err_parity` is set with the byte when parity is enabled and the received parity bit does not match.
- R12: When a frame completes while `rd_valid` is still 1 and not being acknowledged, the new byte replaces the old one and `err_overrun` is set. `rd_ack` clears `rd_valid` and all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| cfg_data_inv | input | 1 | Complement data bits at the register boundary |
| cfg_line_inv | input | 1 | Invert all levels on txd and rxd |
| cfg_msb_first | input | 1 | 1 = data sent bit 7 first |
| cfg_par_en | input | 1 | Insert and check a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| wr_data | input | 8 | Byte to transmit |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Transmitter can take a byte |
| tx_busy | output | 1 | Frame in progress on txd |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rd_ack | input | 1 | Consume the held received byte |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data holds an unread byte |
| err_frame | output | 1 | Stop bit error on held byte |
| err_parity | output | 1 | Parity error on held byte |
| err_overrun | output | 1 | Held byte overwrote an unread one |

## Verification
The assertions assume that the configuration inputs do not change while a frame is in progress. For example, the level `txd` holds when `tx_busy` falls is compared against the live `cfg_line_inv`. The stimulus therefore changes the configuration only while both directions are idle. After each change it waits several bit times, so that the receiver's synchronizer settles and any false start caused by a flipped idle level is rejected before a new frame arrives.

// File: rtl/uart_inv_pkg.sv
package uart_inv_pkg;

    localparam int DATA_W = 8;
    localparam int OSR    = 16;

    typedef struct packed {
        logic data_inv;
        logic line_inv;
        logic msb_first;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_t;

    // Reverse the bit order of a data word
    function automatic logic [DATA_W-1:0] flip_bits(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = d[DATA_W-1-i];
        return r;
    endfunction

    // Map a word to/from shift order (first line bit at index 0)
    function automatic logic [DATA_W-1:0] line_order(input logic [DATA_W-1:0] d,
                                                     input logic msb_first);
        return msb_first ? flip_bits(d) : d;
    endfunction

    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/uart_inv_tx.sv
module uart_inv_tx
    import uart_inv_pkg::*;
#(
    parameter int OS = OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              busy,
    output logic              txd
);
    localparam int CW  = $clog2(OS);
    localparam int BCW = $clog2(DATA_W);

    phase_t            ph;
    logic [CW-1:0]     tcnt;
    logic [BCW-1:0]    bcnt;
    logic [DATA_W-1:0] sh;
    logic              par_q;
    logic              stop2;
    frame_cfg_t        lc;
    logic [DATA_W-1:0] word_in;
    logic              lvl;
    logic              bit_end;

    assign word_in = cfg.data_inv ? ~wr_data : wr_data;
    assign bit_end = tick && (tcnt == CW'(OS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            tcnt  <= '0;
            bcnt  <= '0;
            sh    <= '0;
            par_q <= 1'b0;
            stop2 <= 1'b0;
            lc    <= '0;
        end else begin
            if (ph != PH_IDLE && tick) tcnt <= tcnt + 1'b1;
            case (ph)
                PH_IDLE: if (wr_valid) begin
                    sh    <= line_order(word_in, cfg.msb_first);
                    par_q <= parity_of(word_in, cfg.par_odd);
                    lc    <= cfg;
                    tcnt  <= '0;
                    ph    <= PH_START;
                end
                PH_START: if (bit_end) begin
                    bcnt <= '0;
                    ph   <= PH_DATA;
                end
                PH_DATA: if (bit_end) begin
                    sh   <= sh >> 1;
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == BCW'(DATA_W - 1)) begin
                        stop2 <= 1'b0;
                        ph    <= lc.par_en ? PH_PAR : PH_STOP;
                    end
                end
                PH_PAR: if (bit_end) begin
                    stop2 <= 1'b0;
                    ph    <= PH_STOP;
                end
                PH_STOP: if (bit_end) begin
                    if (lc.two_stop && !stop2) stop2 <= 1'b1;
                    else                       ph    <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (ph)
            PH_START: lvl = 1'b0;
            PH_DATA:  lvl = sh[0];
            PH_PAR:   lvl = par_q;
            default:  lvl = 1'b1;
        endcase
    end

    assign busy     = (ph != PH_IDLE);
    assign wr_ready = (ph == PH_IDLE);
    assign txd      = lvl ^ (busy ? lc.line_inv : cfg.line_inv);

endmodule

// File: rtl/uart_inv_rx.sv
module uart_inv_rx
    import uart_inv_pkg::*;
#(
    parameter int OS = OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              rxd,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun
);
    localparam int CW  = $clog2(OS);
    localparam int BCW = $clog2(DATA_W);

    logic [1:0]        sy;
    logic              ln;
    phase_t            ph;
    logic [CW-1:0]     tcnt;
    logic [BCW-1:0]    bcnt;
    logic [DATA_W-1:0] sh;
    logic              pbit;
    logic              stop2;
    logic              ferr;
    logic              sample;
    logic [DATA_W-1:0] word_out;
    logic              par_bad;

    assign ln       = sy[1] ^ cfg.line_inv;
    assign sample   = tick && (tcnt == CW'(OS - 1));
    assign word_out = line_order(sh, cfg.msb_first) ^ {DATA_W{cfg.data_inv}};
    assign par_bad  = cfg.par_en && (parity_of(sh, cfg.par_odd) != pbit);

    always_ff @(posedge clk) begin
        if (rst) begin
            sy          <= {2{cfg.line_inv}} ^ 2'b11;
            ph          <= PH_IDLE;
            tcnt        <= '0;
            bcnt        <= '0;
            sh          <= '0;
            pbit        <= 1'b0;
            stop2       <= 1'b0;
            ferr        <= 1'b0;
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            sy <= {sy[0], rxd};
            if (rd_ack && rd_valid) begin
                rd_valid    <= 1'b0;
                err_frame   <= 1'b0;
                err_parity  <= 1'b0;
                err_overrun <= 1'b0;
            end
            if (ph != PH_IDLE && tick) tcnt <= tcnt + 1'b1;
            case (ph)
                PH_IDLE: if (tick && !ln) begin
                    tcnt <= '0;
                    ph   <= PH_START;
                end
                PH_START: if (tick && tcnt == CW'(OS / 2 - 1)) begin
                    tcnt <= '0;
                    bcnt <= '0;
                    ferr <= 1'b0;
                    ph   <= ln ? PH_IDLE : PH_DATA;
                end
                PH_DATA: if (sample) begin
                    sh   <= {ln, sh[DATA_W-1:1]};
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == BCW'(DATA_W - 1)) begin
                        stop2 <= 1'b0;
                        ph    <= cfg.par_en ? PH_PAR : PH_STOP;
                    end
                end
                PH_PAR: if (sample) begin
                    pbit <= ln;
                    ph   <= PH_STOP;
                end
                PH_STOP: if (sample) begin
                    if (cfg.two_stop && !stop2) begin
                        stop2 <= 1'b1;
                        ferr  <= !ln;
                    end else begin
                        rd_data     <= word_out;
                        rd_valid    <= 1'b1;
                        err_frame   <= ferr | !ln;
                        err_parity  <= par_bad;
                        err_overrun <= rd_valid && !rd_ack;
                        ph          <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_inv_top.sv
module uart_inv_top
    import uart_inv_pkg::*;
#(
    parameter int OS = OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              cfg_data_inv,
    input  logic              cfg_line_inv,
    input  logic              cfg_msb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              tx_busy,
    output logic              txd,
    input  logic              rxd,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun
);
    frame_cfg_t cfg;

    assign cfg = '{data_inv:  cfg_data_inv,
                   line_inv:  cfg_line_inv,
                   msb_first: cfg_msb_first,
                   par_en:    cfg_par_en,
                   par_odd:   cfg_par_odd,
                   two_stop:  cfg_two_stop};

    uart_inv_tx #(.OS(OS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .cfg      (cfg),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .busy     (tx_busy),
        .txd      (txd)
    );

    uart_inv_rx #(.OS(OS)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick16),
        .cfg         (cfg),
        .rxd         (rxd),
        .rd_ack      (rd_ack),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .err_overrun (err_overrun)
    );

endmodule

// File: rtl/uart_inv_chk.sv
module uart_inv_chk (
    input logic clk,
    input logic rst,
    input logic cfg_line_inv,
    input logic wr_valid,
    input logic wr_ready,
    input logic tx_busy,
    input logic txd,
    input logic rd_valid,
    input logic err_frame,
    input logic err_parity,
    input logic err_overrun
);
    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> tx_busy);

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> (txd == !cfg_line_inv));

    // R2
    start_level_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> (txd == cfg_line_inv));

    // R5
    last_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> ($past(txd) == !cfg_line_inv));

    // R12
    flags_held_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> !(err_frame || err_parity || err_overrun));

endmodule

bind uart_inv_top uart_inv_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_line_inv (cfg_line_inv),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .tx_busy      (tx_busy),
    .txd          (txd),
    .rd_valid     (rd_valid),
    .err_frame    (err_frame),
    .err_parity   (err_parity),
    .err_overrun  (err_overrun)
);

// File: tb/uart_inv_top_tb.sv
module uart_inv_top_tb;
    import uart_inv_pkg::*;

    localparam int BITCLK = 64; // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    frame_cfg_t cf = '0;
    logic [7:0] wr_data = '0;
    logic       wr_valid = 1'b0;
    logic       wr_ready, tx_busy, txd;
    logic       loop_en = 1'b1;
    logic       rxd_drv = 1'b1;
    logic       rxd;
    logic       rd_ack = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, err_frame, err_parity, err_overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    assign rxd = loop_en ? txd : rxd_drv;

    always #2.5 clk = ~clk;

    uart_inv_top u_dut (
        .clk(clk), .rst(rst), .tick16(tick16),
        .cfg_data_inv(cf.data_inv), .cfg_line_inv(cf.line_inv),
        .cfg_msb_first(cf.msb_first), .cfg_par_en(cf.par_en),
        .cfg_par_odd(cf.par_odd), .cfg_two_stop(cf.two_stop),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun)
    );

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div++;
            tick16 = (div % 4 == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected line levels of one frame; returns the bit count
    function automatic int build(input logic [7:0] d, input frame_cfg_t c,
                                 output logic [11:0] lv);
        logic [7:0] b;
        int k;
        lv = '0;
        b = c.data_inv ? ~d : d;
        k = 0;
        lv[k] = 1'b0; k++;
        for (int i = 0; i < 8; i++) begin
            lv[k] = c.msb_first ? b[7-i] : b[i];
            k++;
        end
        if (c.par_en) begin lv[k] = (^b) ^ c.par_odd; k++; end
        lv[k] = 1'b1; k++;
        if (c.two_stop) begin lv[k] = 1'b1; k++; end
        for (int i = 0; i < 12; i++) lv[i] = lv[i] ^ c.line_inv;
        return k;
    endfunction

    task automatic set_cfg(input frame_cfg_t c);
        @(negedge clk);
        cf = c;
        rxd_drv = c.line_inv ^ 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
    endtask

    task automatic do_ack;
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
        chk(rd_valid == 1'b0, "R12 ack clears valid", rd_valid, 0);
    endtask

    // Transmit in loopback, check txd levels and received byte
    task automatic send_check(input logic [7:0] d, input bit exp_ovr, input bit ack);
        logic [11:0] lv;
        int n;
        n = build(d, cf, lv);
        @(negedge clk);
        wr_data = d;
        wr_valid = 1'b1;
        chk(wr_ready == 1'b1, "R8 ready when idle", wr_ready, 1);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(tx_busy == 1'b1 && wr_ready == 1'b0, "R8 busy after accept",
            {tx_busy, wr_ready}, 2'b10);
        for (int k = 0; k < n; k++) begin
            repeat (k == 0 ? BITCLK / 2 : BITCLK) @(negedge clk);
            chk(txd == lv[k], $sformatf("R2/R3/R4/R5/R6/R7 txd bit %0d", k), txd, lv[k]);
            chk(tx_busy == 1'b1, "R8 busy through frame", tx_busy, 1);
        end
        repeat (40) @(negedge clk);
        chk(tx_busy == 1'b0 && wr_ready == 1'b1, "R8 idle after stop",
            {tx_busy, wr_ready}, 2'b01);
        chk(txd == !cf.line_inv, "R7 idle level", txd, !cf.line_inv);
        chk(rd_valid == 1'b1, "R3 rx byte present", rd_valid, 1);
        chk(rd_data == d, "R3/R6 loopback data", rd_data, d);
        chk({err_frame, err_parity, err_overrun} == {2'b00, exp_ovr},
            "R10/R11/R12 flags", {err_frame, err_parity, err_overrun}, {2'b00, exp_ovr});
        if (ack) do_ack();
    endtask

    // Drive raw levels on rxd and check the result
    task automatic drive_raw(input logic [11:0] lv, input int n, input logic [7:0] exp_d,
                             input bit exp_fe, input bit exp_pe, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) rxd_drv = lv[k];
            repeat (BITCLK - 1) @(negedge clk);
        end
        @(negedge clk) rxd_drv = !cf.line_inv;
        repeat (40) @(negedge clk);
        chk(rd_valid == 1'b1, {req, " valid"}, rd_valid, 1);
        chk(rd_data == exp_d, {req, " data"}, rd_data, exp_d);
        chk({err_frame, err_parity} == {exp_fe, exp_pe}, {req, " flags"},
            {err_frame, err_parity}, {exp_fe, exp_pe});
        do_ack();
        repeat (2 * BITCLK) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        frame_cfg_t c;
        logic [11:0] lv;
        int n;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({tx_busy, wr_ready, rd_valid, txd} == 4'b0101, "R1 reset outputs",
            {tx_busy, wr_ready, rd_valid, txd}, 4'b0101);
        chk({err_frame, err_parity, err_overrun} == 3'b000, "R1 reset flags",
            {err_frame, err_parity, err_overrun}, 0);

        // Directed corners: R2 plain, R3 msb first, R4 odd parity, R5 two stops
        c = '0;                                         set_cfg(c); send_check(8'hA5, 0, 1);
        c.msb_first = 1;                                set_cfg(c); send_check(8'h81, 0, 1);
        c = '0; c.par_en = 1; c.par_odd = 1;            set_cfg(c); send_check(8'h00, 0, 1);
        c.par_odd = 0; c.two_stop = 1;                  set_cfg(c); send_check(8'h7F, 0, 1);
        // R6 data inversion, R7 line inversion
        c = '0; c.data_inv = 1; c.par_en = 1;           set_cfg(c); send_check(8'h3C, 0, 1);
        c = '0; c.line_inv = 1; c.par_en = 1;           set_cfg(c); send_check(8'hC3, 0, 1);

        // R12 overrun: two frames without reading
        c = '0; set_cfg(c);
        send_check(8'h11, 0, 0);
        send_check(8'h22, 1, 1);

        // Random frames and formats in loopback
        for (int i = 0; i < 40; i++) begin
            c = frame_cfg_t'($urandom_range(0, 63));
            set_cfg(c);
            send_check(8'($urandom), 0, 1);
        end

        // Raw receive tests
        loop_en = 1'b0;
        // R6 receive side: line carries 0x5A, data_inv set -> read 0xA5
        c = '0; set_cfg(c);
        n = build(8'h5A, c, lv);
        c.data_inv = 1; set_cfg(c);
        drive_raw(lv, n, 8'hA5, 0, 0, "R6 rx data inversion");
        // R7 receive side with inverted line and two stops
        c = '0; c.line_inv = 1; c.two_stop = 1; c.msb_first = 1; set_cfg(c);
        n = build(8'h96, c, lv);
        drive_raw(lv, n, 8'h96, 0, 0, "R7 rx line inversion");
        // R11 parity error
        c = '0; c.par_en = 1; set_cfg(c);
        n = build(8'h37, c, lv);
        lv[9] = ~lv[9];
        drive_raw(lv, n, 8'h37, 0, 1, "R11 parity error");
        // R10 framing error on the second of two stop bits
        c = '0; c.two_stop = 1; set_cfg(c);
        n = build(8'hE4, c, lv);
        lv[n-1] = ~lv[n-1];
        drive_raw(lv, n, 8'hE4, 1, 0, "R10 framing error");
        // R9 short start pulse is rejected
        c = '0; set_cfg(c);
        @(negedge clk) rxd_drv = 1'b0;
        repeat (16) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (12 * BITCLK) @(negedge clk);
        chk(rd_valid == 1'b0, "R9 glitch rejected", rd_valid, 0);
        // R9 a proper frame right after still decodes
        n = build(8'h5C, c, lv);
        drive_raw(lv, n, 8'h5C, 0, 0, "R9 frame after glitch");

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule